// File: doc/BRIEF.md
# Fault Status Register with Priority-Locked Capture

This block keeps the asynchronous fault status of a processor core. Error detectors elsewhere raise one-cycle event strobes. Each strobe carries a cause code, a faulting address, a tag syndrome, a data syndrome, the privilege state and the index of the 16-byte beat within a 64-byte transfer. The block keeps sticky per-cause status bits, a multiple-error flag and the privilege of the latest error, all in one 64-bit status word.

Software reads the status word and clears bits by writing ones to them. The address and the two syndrome fields each hold the highest-priority logged event. Each stays locked until software clears the status bit of the event it holds. An error pin reports the fatal causes, and a trap request goes out while trap-class status is pending and interrupts are enabled.

Top module: `fault_status_unit`

## Requirements
- R1: An accepted event with cause code c (0 to 18) sets status bit 33+c. The bit holds until a write with a one in that position clears it. Zeros in a write have no effect. Codes 19 to 31 are ignored.
- R2: Bit 53 (multiple-error) is set when an event arrives whose status bit is already set and whose class is not hardware-corrected. Bit 53 clears only by writing a one to it. The hardware-corrected codes are 0, 3, 5, 7, 13 and 15.
- R3: Bit 52 takes the privilege input of each applied event. Writing a one to bit 52 clears it unless an event is applied in the same cycle.
- R4: The tag syndrome in bits 19:16 and the data syndrome in bits 8:0 ignore all writes. Bits 63:54, 32:20 and 15:9 always read zero.
- R5: The address output captures the address of an event when it is unlocked, or when the event outranks the locked one. Ranks from high to low are: bus-uncorrectable (codes 1, 10, 11, 12, 14, 16, 17, 18), cache-uncorrectable (2, 4, 6, 8), software-correctable (9), hardware-corrected. An equal or lower rank never overwrites. Clearing the status bit of the held event unlocks the capture but keeps its value.
- R6: The tag syndrome is captured only by codes 14 and 15. The data syndrome is captured only by the other ECC codes (0 to 9, 12, 13). Each follows the R5 rank and unlock rule on its own.
- R7: An ECC event (codes 0 to 9 and 12 to 15) whose beat index is greater than the beat of the last logged ECC event is dropped with no effect. A beat index equal to or lower than that beat starts a new transfer and is logged. Non-ECC events are never dropped.
- R8: If a write clears bit 33+c in the same cycle that an event with code c arrives, the clear wins. The event is then applied one cycle later.
- R9: The error pin is high while status bit 50 or 51 is set (codes 17 and 18).
- R10: The trap request is high when the interrupt enable is high and any trap-masked status bit is set. The default mask covers all 19 bits.
- R11: After reset the status word, the address and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_vld_i | input | 1 | Error event strobe |
| evt_code_i | input | 5 | Cause code of the event |
| evt_addr_i | input | AW | Faulting address |
| evt_tsyn_i | input | 4 | Tag ECC syndrome |
| evt_dsyn_i | input | 9 | Data ECC syndrome |
| evt_priv_i | input | 1 | Privilege state at detection |
| evt_beat_i | input | 2 | 16-byte beat index within a 64-byte transfer |
| sw_wr_en_i | input | 1 | Software write strobe |
| sw_wr_data_i | input | 64 | Write-one-to-clear mask |
| intr_en_i | input | 1 | Interrupt enable |
| fsr_o | output | 64 | Status word |
| far_o | output | AW | Captured fault address |
| err_pin_o | output | 1 | Fatal error pin |
| trap_req_o | output | 1 | Trap request |

## Verification
An event sampled on a rising edge shows in the status word, the address and the syndromes right after that edge. An event deferred by a competing clear shows one edge later. The pin and the trap request are decoded from the registers with no further delay, so they follow the status bits in the same cycle. The bench steps its reference model on each rising edge from the inputs it drove just after the previous edge, and compares every output on the falling edge. Directed checks sample at the same point, so each result is read in the cycle it is due.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int NUM_CODES = 19;
   localparam int CODE_W    = 5;
   localparam int ST_LSB    = 33;
   localparam int ME_BIT    = 53;
   localparam int PV_BIT    = 52;
   localparam int TSYN_W    = 4;
   localparam int TSYN_LSB  = 16;
   localparam int DSYN_W    = 9;
   localparam int DSYN_LSB  = 0;
   localparam int BEAT_W    = 2;
   localparam int FATAL_A   = 17;
   localparam int FATAL_B   = 18;

   typedef enum logic [1:0] {
      PRI_HWC  = 2'd0,
      PRI_SWC  = 2'd1,
      PRI_CUNC = 2'd2,
      PRI_BUNC = 2'd3
   } fsr_pri_e;

   typedef struct packed {
      fsr_pri_e pri;
      logic     ecc;
      logic     tsyn;
      logic     dsyn;
   } fsr_cls_t;

   function automatic fsr_cls_t code_class(input logic [CODE_W-1:0] code);
      fsr_cls_t c;
      c.pri  = PRI_BUNC;
      c.ecc  = 1'b0;
      c.tsyn = 1'b0;
      c.dsyn = 1'b0;
      case (code)
         5'd0, 5'd3, 5'd5, 5'd7, 5'd13: begin c.pri = PRI_HWC;  c.ecc = 1'b1; c.dsyn = 1'b1; end
         5'd2, 5'd4, 5'd6, 5'd8:        begin c.pri = PRI_CUNC; c.ecc = 1'b1; c.dsyn = 1'b1; end
         5'd9:                          begin c.pri = PRI_SWC;  c.ecc = 1'b1; c.dsyn = 1'b1; end
         5'd1, 5'd12:                   begin c.pri = PRI_BUNC; c.ecc = 1'b1; c.dsyn = 1'b1; end
         5'd14:                         begin c.pri = PRI_BUNC; c.ecc = 1'b1; c.tsyn = 1'b1; end
         5'd15:                         begin c.pri = PRI_HWC;  c.ecc = 1'b1; c.tsyn = 1'b1; end
         default:                       c.pri = PRI_BUNC;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/fsr_beat_filter.sv
module fsr_beat_filter #(
   parameter int BW     = 2,
   parameter bit ENABLE = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          in_vld_i,
   input  logic          in_ecc_i,
   input  logic [BW-1:0] in_beat_i,
   output logic          pass_o
);
   generate
      if (BW < 1) begin : g_bad_bw
         $error("fsr_beat_filter: BW must be at least 1");
      end

      if (ENABLE) begin : g_flt
         logic          armed_q;
         logic [BW-1:0] beat_q;
         logic          drop;

         assign drop   = in_vld_i && in_ecc_i && armed_q && (in_beat_i > beat_q);
         assign pass_o = in_vld_i && !drop;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               armed_q <= 1'b0;
               beat_q  <= '0;
            end else if (in_vld_i && in_ecc_i && !drop) begin
               armed_q <= 1'b1;
               beat_q  <= in_beat_i;
            end
         end

         // R7
         later_beat_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_vld_i && in_ecc_i && armed_q && (in_beat_i > beat_q)) |=> $stable(beat_q));
      end else begin : g_bypass
         logic unused_beat;
         assign unused_beat = ^{in_ecc_i, in_beat_i, clk_i, rst_ni};
         assign pass_o = in_vld_i;
      end
   endgenerate
endmodule

// File: rtl/fsr_cap_slot.sv
module fsr_cap_slot
   import fsr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_CODES-1:0] clr_codes_i,
   input  logic                 a_vld_i,
   input  fsr_pri_e             a_pri_i,
   input  logic [CODE_W-1:0]    a_code_i,
   input  logic [W-1:0]         a_val_i,
   input  logic                 b_vld_i,
   input  fsr_pri_e             b_pri_i,
   input  logic [CODE_W-1:0]    b_code_i,
   input  logic [W-1:0]         b_val_i,
   output logic [W-1:0]         val_o
);
   generate
      if (W < 1 || W > 64) begin : g_bad_w
         $error("fsr_cap_slot: W out of range");
      end
   endgenerate

   logic              lock_q, lock_d;
   fsr_pri_e          pri_q, pri_d;
   logic [CODE_W-1:0] own_q, own_d;
   logic [W-1:0]      val_q, val_d;
   logic              owner_clr;

   assign owner_clr = lock_q && clr_codes_i[own_q];

   always_comb begin
      lock_d = lock_q && !owner_clr;
      pri_d  = pri_q;
      own_d  = own_q;
      val_d  = val_q;
      if (a_vld_i && (!lock_d || (a_pri_i > pri_d))) begin
         lock_d = 1'b1;
         pri_d  = a_pri_i;
         own_d  = a_code_i;
         val_d  = a_val_i;
      end
      if (b_vld_i && (!lock_d || (b_pri_i > pri_d))) begin
         lock_d = 1'b1;
         pri_d  = b_pri_i;
         own_d  = b_code_i;
         val_d  = b_val_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
         pri_q  <= PRI_HWC;
         own_q  <= '0;
         val_q  <= '0;
      end else begin
         lock_q <= lock_d;
         pri_q  <= pri_d;
         own_q  <= own_d;
         val_q  <= val_d;
      end
   end

   assign val_o = val_q;

   // R5
   lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !clr_codes_i[own_q]) |=> lock_q);

   // R6
   locked_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !clr_codes_i[own_q] && !(a_vld_i && (a_pri_i > pri_q)) && !(b_vld_i && (b_pri_i > pri_q)))
      |=> $stable(val_q));
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
   import fsr_pkg::*;
#(
   parameter int                   AW        = 48,
   parameter logic [NUM_CODES-1:0] TRAP_MASK = '1,
   parameter bit                   FILTER_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_vld_i,
   input  logic [CODE_W-1:0] evt_code_i,
   input  logic [AW-1:0]     evt_addr_i,
   input  logic [TSYN_W-1:0] evt_tsyn_i,
   input  logic [DSYN_W-1:0] evt_dsyn_i,
   input  logic              evt_priv_i,
   input  logic [BEAT_W-1:0] evt_beat_i,
   input  logic              sw_wr_en_i,
   input  logic [63:0]       sw_wr_data_i,
   input  logic              intr_en_i,
   output logic [63:0]       fsr_o,
   output logic [AW-1:0]     far_o,
   output logic              err_pin_o,
   output logic              trap_req_o
);
   generate
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("fault_status_unit: AW out of range");
      end
      if (ST_LSB + NUM_CODES > PV_BIT) begin : g_bad_map
         $error("fault_status_unit: status field overlaps flag bits");
      end
   endgenerate

   // incoming event classification and beat filter
   fsr_cls_t f_cls;
   logic     f_ok, f_pass, f_conflict, f_apply;

   assign f_cls = code_class(evt_code_i);
   assign f_ok  = evt_vld_i && (evt_code_i < CODE_W'(NUM_CODES));

   fsr_beat_filter #(.BW(BEAT_W), .ENABLE(FILTER_EN)) u_filter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_vld_i  (f_ok),
      .in_ecc_i  (f_cls.ecc),
      .in_beat_i (evt_beat_i),
      .pass_o    (f_pass)
   );

   // write-one-to-clear masks
   logic [NUM_CODES-1:0] clr;
   logic                 me_clr, pv_clr;
   logic                 unused_wr;

   assign clr       = sw_wr_en_i ? sw_wr_data_i[ST_LSB +: NUM_CODES] : '0;
   assign me_clr    = sw_wr_en_i && sw_wr_data_i[ME_BIT];
   assign pv_clr    = sw_wr_en_i && sw_wr_data_i[PV_BIT];
   assign unused_wr = ^{sw_wr_data_i[63:54], sw_wr_data_i[32:0]};

   assign f_conflict = f_pass && clr[evt_code_i];
   assign f_apply    = f_pass && !f_conflict;

   // deferred event held for one cycle after losing to a clear
   logic              pnd_vld_q;
   logic [CODE_W-1:0] pnd_code_q;
   logic [AW-1:0]     pnd_addr_q;
   logic [TSYN_W-1:0] pnd_tsyn_q;
   logic [DSYN_W-1:0] pnd_dsyn_q;
   logic              pnd_priv_q;
   fsr_cls_t          p_cls;
   logic              unused_cls;

   assign p_cls      = code_class(pnd_code_q);
   assign unused_cls = p_cls.ecc;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pnd_vld_q  <= 1'b0;
         pnd_code_q <= '0;
         pnd_addr_q <= '0;
         pnd_tsyn_q <= '0;
         pnd_dsyn_q <= '0;
         pnd_priv_q <= 1'b0;
      end else begin
         pnd_vld_q <= f_conflict;
         if (f_conflict) begin
            pnd_code_q <= evt_code_i;
            pnd_addr_q <= evt_addr_i;
            pnd_tsyn_q <= evt_tsyn_i;
            pnd_dsyn_q <= evt_dsyn_i;
            pnd_priv_q <= evt_priv_i;
         end
      end
   end

   // sticky status, multiple-error and privilege flags
   logic [NUM_CODES-1:0] st_q, st_d;
   logic                 me_q, me_d, pv_q, pv_d;

   always_comb begin
      st_d = st_q & ~clr;
      me_d = me_q && !me_clr;
      pv_d = pv_q && !pv_clr;
      if (pnd_vld_q) begin
         if ((p_cls.pri != PRI_HWC) && st_d[pnd_code_q]) me_d = 1'b1;
         st_d[pnd_code_q] = 1'b1;
         pv_d = pnd_priv_q;
      end
      if (f_apply) begin
         if ((f_cls.pri != PRI_HWC) && st_d[evt_code_i]) me_d = 1'b1;
         st_d[evt_code_i] = 1'b1;
         pv_d = evt_priv_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= '0;
         me_q <= 1'b0;
         pv_q <= 1'b0;
      end else begin
         st_q <= st_d;
         me_q <= me_d;
         pv_q <= pv_d;
      end
   end

   // priority-locked captures: address, tag syndrome, data syndrome
   logic [TSYN_W-1:0] tsyn_q;
   logic [DSYN_W-1:0] dsyn_q;

   fsr_cap_slot #(.W(AW)) u_far (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_codes_i (clr),
      .a_vld_i (pnd_vld_q), .a_pri_i (p_cls.pri), .a_code_i (pnd_code_q), .a_val_i (pnd_addr_q),
      .b_vld_i (f_apply),   .b_pri_i (f_cls.pri), .b_code_i (evt_code_i), .b_val_i (evt_addr_i),
      .val_o (far_o)
   );

   fsr_cap_slot #(.W(TSYN_W)) u_tsyn (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_codes_i (clr),
      .a_vld_i (pnd_vld_q && p_cls.tsyn), .a_pri_i (p_cls.pri), .a_code_i (pnd_code_q), .a_val_i (pnd_tsyn_q),
      .b_vld_i (f_apply && f_cls.tsyn),   .b_pri_i (f_cls.pri), .b_code_i (evt_code_i), .b_val_i (evt_tsyn_i),
      .val_o (tsyn_q)
   );

   fsr_cap_slot #(.W(DSYN_W)) u_dsyn (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_codes_i (clr),
      .a_vld_i (pnd_vld_q && p_cls.dsyn), .a_pri_i (p_cls.pri), .a_code_i (pnd_code_q), .a_val_i (pnd_dsyn_q),
      .b_vld_i (f_apply && f_cls.dsyn),   .b_pri_i (f_cls.pri), .b_code_i (evt_code_i), .b_val_i (evt_dsyn_i),
      .val_o (dsyn_q)
   );

   // status word and side outputs
   always_comb begin
      fsr_o = '0;
      fsr_o[ST_LSB +: NUM_CODES] = st_q;
      fsr_o[ME_BIT]              = me_q;
      fsr_o[PV_BIT]              = pv_q;
      fsr_o[TSYN_LSB +: TSYN_W]  = tsyn_q;
      fsr_o[DSYN_LSB +: DSYN_W]  = dsyn_q;
   end

   assign err_pin_o  = st_q[FATAL_A] | st_q[FATAL_B];
   assign trap_req_o = intr_en_i && |(st_q & TRAP_MASK);

   // R1
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_wr_en_i |=> ((st_q & $past(st_q)) == $past(st_q)));

   // R2
   me_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(me_q) |-> $past(pnd_vld_q || f_apply));

   // R8
   clear_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      f_conflict |=> pnd_vld_q);

   // R9
   pin_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_pin_o) |-> $past(sw_wr_en_i));

   // R10
   trap_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_req_o |-> intr_en_i);
endmodule

// File: tb/fault_status_unit_tb.sv
`timescale 1ns/1ps
module fault_status_unit_tb;
   localparam int AW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_vld = 1'b0;
   logic [4:0]    evt_code = '0;
   logic [AW-1:0] evt_addr = '0;
   logic [3:0]    evt_tsyn = '0;
   logic [8:0]    evt_dsyn = '0;
   logic          evt_priv = 1'b0;
   logic [1:0]    evt_beat = '0;
   logic          wr_en = 1'b0;
   logic [63:0]   wr_data = '0;
   logic          intr_en = 1'b0;
   logic [63:0]   fsr;
   logic [AW-1:0] far;
   logic          err_pin, trap_req;

   always #2.5 clk = ~clk;

   fault_status_unit #(.AW(AW)) u_dut (
      .clk_i (clk), .rst_ni (rst_n),
      .evt_vld_i (evt_vld), .evt_code_i (evt_code), .evt_addr_i (evt_addr),
      .evt_tsyn_i (evt_tsyn), .evt_dsyn_i (evt_dsyn), .evt_priv_i (evt_priv),
      .evt_beat_i (evt_beat), .sw_wr_en_i (wr_en), .sw_wr_data_i (wr_data),
      .intr_en_i (intr_en), .fsr_o (fsr), .far_o (far),
      .err_pin_o (err_pin), .trap_req_o (trap_req)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [18:0] m_st = '0;
   bit          m_me = 0, m_pv = 0;
   bit          m_lk [3] = '{0, 0, 0};
   int          m_pr [3] = '{0, 0, 0};
   int          m_ow [3] = '{0, 0, 0};
   logic [63:0] m_sv [3] = '{64'd0, 64'd0, 64'd0};
   bit          m_armed = 0;
   int          m_abeat = 0;
   bit          q_v = 0;
   int          q_c = 0;
   logic [63:0] q_a = '0;
   logic [3:0]  q_t = '0;
   logic [8:0]  q_d = '0;
   bit          q_p = 0;

   function automatic int m_pri(input int c);
      if (c inside {1, 10, 11, 12, 14, 16, 17, 18}) return 3;
      if (c inside {2, 4, 6, 8}) return 2;
      if (c == 9) return 1;
      return 0;
   endfunction
   function automatic bit m_ecc(input int c);
      return (c <= 9) || (c >= 12 && c <= 15);
   endfunction
   function automatic bit m_tag(input int c);
      return (c == 14) || (c == 15);
   endfunction

   task automatic m_try(input int s, input int p, input int c, input logic [63:0] v);
      if (!m_lk[s] || p > m_pr[s]) begin
         m_lk[s] = 1; m_pr[s] = p; m_ow[s] = c; m_sv[s] = v;
      end
   endtask

   task automatic m_apply(input int c, input logic [63:0] a, input logic [3:0] t,
                          input logic [8:0] d, input bit p);
      if (m_pri(c) != 0 && m_st[c]) m_me = 1;
      m_st[c] = 1'b1;
      m_pv = p;
      m_try(0, m_pri(c), c, a);
      if (m_tag(c)) m_try(1, m_pri(c), c, {60'd0, t});
      else if (m_ecc(c)) m_try(2, m_pri(c), c, {55'd0, d});
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = '0; m_me = 0; m_pv = 0; m_armed = 0; m_abeat = 0; q_v = 0;
         for (int s = 0; s < 3; s++) begin m_lk[s] = 0; m_pr[s] = 0; m_ow[s] = 0; m_sv[s] = '0; end
      end else begin
         logic [18:0] cl;
         bit fv, conf;
         int c;
         cl = wr_en ? wr_data[51:33] : '0;
         c  = int'(evt_code);
         fv = evt_vld && (c < 19);
         if (fv && m_ecc(c)) begin
            if (m_armed && int'(evt_beat) > m_abeat) fv = 0;
            else begin m_armed = 1; m_abeat = int'(evt_beat); end
         end
         conf = fv && cl[c];
         for (int s = 0; s < 3; s++) if (m_lk[s] && cl[m_ow[s]]) m_lk[s] = 0;
         m_st = m_st & ~cl;
         if (wr_en && wr_data[53]) m_me = 0;
         if (wr_en && wr_data[52]) m_pv = 0;
         if (q_v) m_apply(q_c, q_a, q_t, q_d, q_p);
         if (fv && !conf) m_apply(c, {16'd0, evt_addr}, evt_tsyn, evt_dsyn, evt_priv);
         q_v = conf;
         if (conf) begin
            q_c = c; q_a = {16'd0, evt_addr}; q_t = evt_tsyn; q_d = evt_dsyn; q_p = evt_priv;
         end
      end
   end

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      string pfx;
      cyc_cnt++;
      pfx = rst_n ? "" : "R11/";
      chk({pfx, "R1 status"},   {45'd0, fsr[51:33]}, {45'd0, m_st});
      chk({pfx, "R2 multi"},    {63'd0, fsr[53]},    {63'd0, m_me});
      chk({pfx, "R3 priv"},     {63'd0, fsr[52]},    {63'd0, m_pv});
      chk({pfx, "R4 zero"},     fsr & 64'hFFC0_0001_FFF0_FE00, 64'd0);
      chk({pfx, "R6 tag syn"},  {60'd0, fsr[19:16]}, m_sv[1]);
      chk({pfx, "R6 data syn"}, {55'd0, fsr[8:0]},   m_sv[2]);
      chk({pfx, "R5 address"},  {16'd0, far},        m_sv[0]);
      chk({pfx, "R9 pin"},      {63'd0, err_pin},    {63'd0, m_st[17] | m_st[18]});
      chk({pfx, "R10 trap"},    {63'd0, trap_req},   {63'd0, intr_en && (m_st != 0)});
      if (cyc_cnt > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc_cnt);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic drive(input bit ev, input int c, input logic [AW-1:0] a, input logic [3:0] t,
                        input logic [8:0] d, input bit p, input int b,
                        input bit we, input logic [63:0] wd);
      evt_vld = ev; evt_code = 5'(c); evt_addr = a; evt_tsyn = t; evt_dsyn = d;
      evt_priv = p; evt_beat = 2'(b); wr_en = we; wr_data = wd;
      step();
      evt_vld = 0; wr_en = 0; wr_data = '0;
   endtask

   task automatic ev(input int c, input logic [AW-1:0] a, input logic [3:0] t,
                     input logic [8:0] d, input bit p, input int b);
      drive(1, c, a, t, d, p, b, 0, '0);
   endtask

   task automatic clr(input logic [63:0] m);
      drive(0, 0, '0, '0, '0, 0, 0, 1, m);
   endtask

   initial begin
      logic [63:0] snap;
      repeat (4) step();
      chk("R11 reset word", fsr, 64'd0);
      chk("R11 reset addr", {16'd0, far}, 64'd0);
      rst_n = 1;
      step();

      // R5: rank-locked address capture
      ev(0, 48'h1000, 4'h0, 9'h011, 1, 0);
      chk("R5 first capture", {16'd0, far}, 64'h1000);
      chk("R3 priv captured", {63'd0, fsr[52]}, 64'd1);
      ev(1, 48'h2000, 4'h0, 9'h022, 0, 0);
      chk("R5 higher overwrites", {16'd0, far}, 64'h2000);
      chk("R6 data syn overwrite", {55'd0, fsr[8:0]}, 64'h022);
      ev(3, 48'h3000, 4'h0, 9'h033, 0, 0);
      chk("R5 lower ignored", {16'd0, far}, 64'h2000);
      clr(64'd1 << 34);
      chk("R5 value kept after unlock", {16'd0, far}, 64'h2000);
      ev(3, 48'h4000, 4'h0, 9'h044, 0, 0);
      chk("R5 capture after unlock", {16'd0, far}, 64'h4000);
      chk("R2 corrected repeat", {63'd0, fsr[53]}, 64'd0);

      // R2: software-correctable repeat
      ev(9, 48'h5000, 4'h0, 9'h055, 0, 0);
      ev(9, 48'h5040, 4'h0, 9'h056, 0, 0);
      chk("R2 repeat sets multi", {63'd0, fsr[53]}, 64'd1);
      clr(64'd1 << 53);
      chk("R2 multi cleared", {63'd0, fsr[53]}, 64'd0);

      // R1 / R4: zero writes and read-only syndromes
      clr(64'd0);
      chk("R1 zero write keeps bit", {63'd0, fsr[42]}, 64'd1);
      snap = fsr;
      clr('1);
      chk("R4 syndromes ignore write", fsr & 64'h000F_01FF, snap & 64'h000F_01FF);
      chk("R1 all cleared", {45'd0, fsr[51:33]}, 64'd0);

      // R6: tag syndrome
      ev(15, 48'h6000, 4'h5, 9'h0, 0, 0);
      ev(14, 48'h6100, 4'h9, 9'h0, 0, 0);
      chk("R6 tag overwrite", {60'd0, fsr[19:16]}, 64'h9);
      ev(15, 48'h6200, 4'h3, 9'h0, 0, 0);
      chk("R6 tag kept", {60'd0, fsr[19:16]}, 64'h9);
      clr('1);

      // R7: beat filter
      ev(0, 48'h7000, 4'h0, 9'h070, 0, 0);
      ev(1, 48'h7010, 4'h0, 9'h071, 0, 2);
      chk("R7 later beat dropped", {63'd0, fsr[34]}, 64'd0);
      ev(10, 48'h7020, 4'h0, 9'h0, 0, 3);
      chk("R7 non-ECC kept", {63'd0, fsr[43]}, 64'd1);
      ev(1, 48'h7030, 4'h0, 9'h072, 0, 0);
      chk("R7 new transfer logged", {63'd0, fsr[34]}, 64'd1);
      clr('1);

      // R8: clear beats a simultaneous event, event lands a cycle later
      ev(9, 48'h8000, 4'h0, 9'h080, 0, 0);
      drive(1, 9, 48'h8040, 4'h0, 9'h081, 1, 0, 1, 64'd1 << 42);
      chk("R8 clear wins", {63'd0, fsr[42]}, 64'd0);
      step();
      chk("R8 event applied next cycle", {63'd0, fsr[42]}, 64'd1);
      drive(1, 9, 48'h8080, 4'h0, 9'h082, 0, 0, 1, 64'd1 << 42);
      ev(2, 48'h8100, 4'h0, 9'h083, 0, 0);
      chk("R8 replay with fresh event", {63'd0, fsr[42]}, 64'd1);
      clr('1);

      // R9 / R10
      ev(17, 48'h9000, 4'h0, 9'h0, 0, 0);
      chk("R9 pin high", {63'd0, err_pin}, 64'd1);
      chk("R10 trap off", {63'd0, trap_req}, 64'd0);
      intr_en = 1; #0.5;
      chk("R10 trap on", {63'd0, trap_req}, 64'd1);
      clr(64'd1 << 50);
      chk("R9 pin low", {63'd0, err_pin}, 64'd0);
      ev(25, 48'h9100, 4'h0, 9'h0, 0, 0);
      chk("R1 invalid code ignored", {45'd0, fsr[51:33]}, 64'd0);

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         intr_en = $urandom_range(0, 1) == 1;
         drive(r < 55, int'($urandom_range(0, 20)), 48'($urandom) << 6, 4'($urandom),
               9'($urandom), $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
               r > 40 && r < 70, {$urandom, $urandom} & {$urandom, $urandom});
      end
      repeat (3) step();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule